// File: doc/BRIEF.md
# Latched Interrupt Controller with Saturating Event Counters

This block gathers single-cycle event pulses into sticky status flags and drives one interrupt pin. Each status register holds its sticky flags in the upper byte. The lower byte holds the per-flag enables at the same position minus eight. A flag latches whether or not it is enabled, but only an enabled flag can drive the pin. Reading a status register returns the flags and then clears them. An event that arrives in the same cycle as the read survives the clear.

Two saturating counters are included. An 8-bit counter counts false-carrier pulses. A 16-bit counter counts receive symbol errors, but only while the receive-valid qualifier is high and loopback is off. Both counters clear when read. When a counter first passes its half-full point, it raises an event into status register A. A small configuration register selects the pin polarity and can force the interrupt active for testing.

Top module: `latched_irq_ctrl`

## Requirements
- R1: An event pulse sets its status flag on the next clock edge regardless of its enable. In status register A (address 0), `evt_a[k]` sets bit 10+k, the false-carrier half-full event sets bit 9, and the receive-error half-full event sets bit 8. In status register B (address 1), `evt_b[k]` sets bit 8+k.
- R2: Reading a status register returns the current flags in bits 15:8 and the enables in bits 7:0, then clears the flags. A flag whose event is present in the same cycle as the read is set after the read.
- R3: A write to a status register loads bits 7:0 into the enables and leaves the flags unchanged. Enables reset to 0.
- R4: The interrupt is active when any flag is set together with its enable (flag bit 8+j and enable bit j), or when the force bit is set. Otherwise it is inactive.
- R5: Bit 3 of the configuration register (address 2, reset value 0x0008) selects the polarity. When bit 3 is 1, `irq_pin` idles high and goes low when the interrupt is active. When bit 3 is 0, the pin idles low and goes high when the interrupt is active.
- R6: While bit 2 of the configuration register is set, the interrupt is held active.
- R7: The false-carrier counter (address 3, bits 7:0) increments once per `fc_evt` cycle and holds at 0xFF. A read returns the count and clears it. An event in the same cycle as the read leaves the count at 1.
- R8: The receive-error counter (address 4) increments in each cycle where `rx_dv` and `rx_sym_err` are both high and `loopback` is low. It holds at 0xFFFF and clears when read.
- R9: A half-full event fires once, in the cycle in which a counter moves from 0x7F to 0x80 (false carrier) or from 0x7FFF to 0x8000 (receive error). Further counting without a clear does not fire it again.
- R10: Reads of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_a | input | 6 | Event pulses for status register A flags 15:10 |
| evt_b | input | 8 | Event pulses for status register B flags 15:8 |
| fc_evt | input | 1 | False-carrier event pulse |
| rx_dv | input | 1 | Receive-valid qualifier |
| rx_sym_err | input | 1 | Invalid receive symbol flag |
| loopback | input | 1 | Loopback active; blocks receive-error counting |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clears on the following edge |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle in which `reg_rd` is high |
| irq_pin | output | 1 | Interrupt pin, polarity per R5 |

## Verification
An event driven in cycle N is visible in the flags, the counters and `irq_pin` after the edge that ends cycle N. The bench therefore drives its inputs just after a rising edge and samples `irq_pin` one edge later. Read data is combinational from the stored state, so the bench samples `reg_rdata` before the edge that carries out the clear. The follow-up read, made after that edge, shows whether the clear or the colliding event took effect. The half-full checks read the flag just before the crossing and again just after it, which pins the event to a single count step.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int REG_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_STAT = 2;
    localparam int EVA_W    = 6;
    localparam int FC_W     = 8;
    localparam int RX_W     = 16;

    localparam int CFG_POL_BIT   = 3;
    localparam int CFG_FORCE_BIT = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_STAT_A = 3'd0,
        ADR_STAT_B = 3'd1,
        ADR_CFG    = 3'd2,
        ADR_FC     = 3'd3,
        ADR_RX     = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic active_low;
        logic force_irq;
    } irq_cfg_t;

    localparam irq_cfg_t CFG_RST = '{active_low: 1'b1, force_irq: 1'b0};

    function automatic logic [REG_W-1:0] pack_stat(logic [BYTE_W-1:0] flags,
                                                   logic [BYTE_W-1:0] enables);
        return {flags, enables};
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(irq_cfg_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[CFG_POL_BIT]   = c.active_low;
        v[CFG_FORCE_BIT] = c.force_irq;
        return v;
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         half_evt
);
    localparam logic [W-1:0] MAX_V   = {W{1'b1}};
    localparam logic [W-1:0] BELOW_H = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] cnt_nxt;

    always_comb begin
        if (clr)
            cnt_nxt = inc ? W'(1) : '0;
        else if (inc && cnt != MAX_V)
            cnt_nxt = cnt + W'(1);
        else
            cnt_nxt = cnt;
    end

    // one pulse on the step across half full
    assign half_evt = inc && !clr && (cnt == BELOW_H);

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAX_V && !clr) |=> (cnt == MAX_V)); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (clr && !inc) |=> (cnt == '0)); // R8
    AST_HALF_ONCE: assert property (@(posedge clk) disable iff (rst)
        half_evt |=> !half_evt); // R9

endmodule

// File: rtl/stat_en_reg.sv
module stat_en_reg #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic         wr,
    input  logic         rd,
    input  logic [N-1:0] wr_en,
    output logic [N-1:0] flags,
    output logic [N-1:0] enables
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags <= (rd ? '0 : flags) | evt;
            if (wr) enables <= wr_en;
        end
    end

    AST_EVT_LATCH: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R1
    AST_RD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd && evt == '0) |=> (flags == '0)); // R2
    AST_WR_ENABLE: assert property (@(posedge clk) disable iff (rst)
        wr |=> (enables == $past(wr_en))); // R3

endmodule

// File: rtl/latched_irq_ctrl.sv
module latched_irq_ctrl
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [EVA_W-1:0]  evt_a,
    input  logic [BYTE_W-1:0] evt_b,
    input  logic              fc_evt,
    input  logic              rx_dv,
    input  logic              rx_sym_err,
    input  logic              loopback,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq_pin
);
    logic [FC_W-1:0] fc_cnt;
    logic [RX_W-1:0] rx_cnt;
    logic            fc_half, rx_half;
    logic            fc_clr, rx_clr, rx_inc;
    irq_cfg_t        cfg;
    logic            irq_active;

    logic [BYTE_W-1:0] evt_vec  [NUM_STAT];
    logic [BYTE_W-1:0] flag_vec [NUM_STAT];
    logic [BYTE_W-1:0] en_vec   [NUM_STAT];
    logic [NUM_STAT-1:0] pend;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[REG_W-1:BYTE_W], reg_wdata[BYTE_W-1:CFG_POL_BIT+1],
                            reg_wdata[CFG_FORCE_BIT-1:0]};

    assign evt_vec[0] = {evt_a, fc_half, rx_half};
    assign evt_vec[1] = evt_b;

    generate
        for (genvar g = 0; g < NUM_STAT; g++) begin : g_stat
            logic sel;
            assign sel = (reg_addr == ADDR_W'(g));
            stat_en_reg #(.N(BYTE_W)) u_reg (
                .clk     (clk),
                .rst     (rst),
                .evt     (evt_vec[g]),
                .wr      (reg_wr && sel),
                .rd      (reg_rd && sel),
                .wr_en   (reg_wdata[BYTE_W-1:0]),
                .flags   (flag_vec[g]),
                .enables (en_vec[g])
            );
            assign pend[g] = |(flag_vec[g] & en_vec[g]);
        end
    endgenerate

    assign fc_clr = reg_rd && (reg_addr == ADR_FC);
    assign rx_clr = reg_rd && (reg_addr == ADR_RX);
    assign rx_inc = rx_dv && rx_sym_err && !loopback;

    sat_counter #(.W(FC_W)) u_fc (
        .clk(clk), .rst(rst), .inc(fc_evt), .clr(fc_clr),
        .cnt(fc_cnt), .half_evt(fc_half)
    );

    sat_counter #(.W(RX_W)) u_rx (
        .clk(clk), .rst(rst), .inc(rx_inc), .clr(rx_clr),
        .cnt(rx_cnt), .half_evt(rx_half)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= CFG_RST;
        else if (reg_wr && reg_addr == ADR_CFG)
            cfg <= '{active_low: reg_wdata[CFG_POL_BIT], force_irq: reg_wdata[CFG_FORCE_BIT]};
    end

    assign irq_active = (|pend) || cfg.force_irq;
    assign irq_pin    = cfg.active_low ? !irq_active : irq_active;

    always_comb begin
        case (reg_addr)
            ADR_STAT_A: reg_rdata = pack_stat(flag_vec[0], en_vec[0]);
            ADR_STAT_B: reg_rdata = pack_stat(flag_vec[1], en_vec[1]);
            ADR_CFG:    reg_rdata = pack_cfg(cfg);
            ADR_FC:     reg_rdata = REG_W'(fc_cnt);
            ADR_RX:     reg_rdata = REG_W'(rx_cnt);
            default:    reg_rdata = '0;
        endcase
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ((flag_vec[0] & en_vec[0]) == '0 && (flag_vec[1] & en_vec[1]) == '0 && !cfg.force_irq)
        |-> (irq_pin == cfg.active_low)); // R4
    AST_FORCE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        cfg.force_irq |-> (irq_pin != cfg.active_low)); // R6
    AST_LOOPBACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loopback && !rx_clr) |=> $stable(rx_cnt)); // R8

endmodule

// File: tb/tb_latched_irq_ctrl.sv
module tb_latched_irq_ctrl;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  evt_a = '0;
    logic [7:0]  evt_b = '0;
    logic        fc_evt = 1'b0, rx_dv = 1'b0, rx_sym_err = 1'b0, loopback = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_pin;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cyc    = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    latched_irq_ctrl dut (
        .clk(clk), .rst(rst), .evt_a(evt_a), .evt_b(evt_b), .fc_evt(fc_evt),
        .rx_dv(rx_dv), .rx_sym_err(rx_sym_err), .loopback(loopback),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin)
    );

    always @(posedge clk) begin
        n_cyc <= n_cyc + 1;
        if (n_cyc == WATCHDOG && !done) begin
            $display("FAIL watchdog expired after %0d cycles (got hang, expected finish)", n_cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic pulse_a(input logic [5:0] v);
        evt_a = v; cyc(); evt_a = '0;
    endtask

    task automatic fc_burst(input int n);
        fc_evt = 1'b1; repeat (n) cyc(); fc_evt = 1'b0;
    endtask

    task automatic rx_burst(input int n);
        rx_dv = 1'b1; rx_sym_err = 1'b1; repeat (n) cyc(); rx_dv = 1'b0; rx_sym_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(3'd2, d); chk("R10 cfg reset value", d, 16'h0008);
        chk("R5 idle pin high after reset", 16'(irq_pin), 16'h1);
        rd(3'd0, d); chk("R3 status A reset", d, 16'h0000);
        rd(3'd3, d); chk("R7 fc count reset", d, 16'h0000);
        rd(3'd4, d); chk("R8 rx count reset", d, 16'h0000);
        rd(3'd7, d); chk("R10 unmapped address", d, 16'h0000);
    endtask

    task automatic t_latch();
        logic [15:0] d;
        pulse_a(6'b000101);
        chk("R4 disabled flags keep pin idle", 16'(irq_pin), 16'h1);
        rd(3'd0, d); chk("R1 flags latch without enable", d, 16'h1400);
        rd(3'd0, d); chk("R2 flags cleared by read", d, 16'h0000);
    endtask

    task automatic t_enable();
        logic [15:0] d;
        wr(3'd0, 16'hFF04);
        rd(3'd0, d); chk("R3 write loads enables only", d, 16'h0004);
        pulse_a(6'b000010);
        chk("R4 disabled flag no interrupt", 16'(irq_pin), 16'h1);
        pulse_a(6'b000001);
        chk("R4 enabled flag asserts pin", 16'(irq_pin), 16'h0);
        rd(3'd0, d); chk("R1 both flags held", d, 16'h0C04);
        chk("R2 pin releases after clearing read", 16'(irq_pin), 16'h1);
    endtask

    task automatic t_collide();
        logic [15:0] d;
        evt_a = 6'b000001;
        rd(3'd0, d);
        evt_a = '0;
        chk("R2 read during event shows old flags", d, 16'h0004);
        chk("R2 colliding event survives clear (pin)", 16'(irq_pin), 16'h0);
        rd(3'd0, d); chk("R2 colliding event survives clear", d, 16'h0404);
    endtask

    task automatic t_polarity();
        logic [15:0] d;
        wr(3'd1, 16'h0080);
        wr(3'd2, 16'h0000);
        chk("R5 low polarity idles low", 16'(irq_pin), 16'h0);
        evt_b = 8'h80; cyc(); evt_b = '0;
        chk("R5 low polarity active high", 16'(irq_pin), 16'h1);
        rd(3'd1, d); chk("R1 status B bit 15", d, 16'h8080);
        chk("R5 low polarity back to idle", 16'(irq_pin), 16'h0);
        wr(3'd2, 16'h0008);
        chk("R5 high polarity idle", 16'(irq_pin), 16'h1);
    endtask

    task automatic t_force();
        wr(3'd2, 16'h000C);
        chk("R6 force asserts pin", 16'(irq_pin), 16'h0);
        repeat (5) cyc();
        chk("R6 force held while set", 16'(irq_pin), 16'h0);
        wr(3'd2, 16'h0004);
        chk("R6 force with low polarity", 16'(irq_pin), 16'h1);
        wr(3'd2, 16'h0008);
        chk("R6 release force", 16'(irq_pin), 16'h1);
    endtask

    task automatic t_fc_count();
        logic [15:0] d;
        wr(3'd0, 16'h0000);
        fc_burst(5);
        rd(3'd3, d); chk("R7 fc counts pulses", d, 16'h0005);
        rd(3'd3, d); chk("R7 fc clear on read", d, 16'h0000);
        fc_burst(3);
        fc_evt = 1'b1;
        rd(3'd3, d);
        fc_evt = 1'b0;
        chk("R7 fc read during event", d, 16'h0003);
        rd(3'd3, d); chk("R7 fc event wins over clear", d, 16'h0001);
        rd(3'd3, d); chk("R7 fc cleared", d, 16'h0000);
    endtask

    task automatic t_fc_half();
        logic [15:0] d;
        rd(3'd0, d);
        wr(3'd0, 16'h0002);
        fc_burst(127);
        chk("R9 fc below half no interrupt", 16'(irq_pin), 16'h1);
        rd(3'd0, d); chk("R9 fc 0x7F no half flag", d, 16'h0002);
        fc_burst(1);
        chk("R9 fc crossing asserts pin", 16'(irq_pin), 16'h0);
        rd(3'd0, d); chk("R9 fc half flag bit 9", d, 16'h0202);
        fc_burst(20);
        rd(3'd0, d); chk("R9 fc half fires once", d, 16'h0002);
        fc_burst(200);
        rd(3'd3, d); chk("R7 fc saturates at 0xFF", d, 16'h00FF);
        rd(3'd3, d); chk("R7 fc cleared after saturation", d, 16'h0000);
    endtask

    task automatic t_rx_qual();
        logic [15:0] d;
        loopback = 1'b1; rx_burst(10); loopback = 1'b0;
        rx_dv = 1'b1; repeat (10) cyc(); rx_dv = 1'b0;
        rx_sym_err = 1'b1; repeat (10) cyc(); rx_sym_err = 1'b0;
        rd(3'd4, d); chk("R8 rx blocked by loopback or missing qualifier", d, 16'h0000);
        rx_burst(4);
        rd(3'd4, d); chk("R8 rx counts qualified errors", d, 16'h0004);
        rd(3'd4, d); chk("R8 rx clear on read", d, 16'h0000);
    endtask

    task automatic t_rx_half();
        logic [15:0] d;
        wr(3'd0, 16'h0001);
        rx_burst(32767);
        rd(3'd0, d); chk("R9 rx 0x7FFF no half flag", d, 16'h0001);
        chk("R9 rx below half pin idle", 16'(irq_pin), 16'h1);
        rx_burst(1);
        chk("R9 rx crossing asserts pin", 16'(irq_pin), 16'h0);
        rd(3'd0, d); chk("R9 rx half flag bit 8", d, 16'h0101);
        rx_burst(70000 - 32768);
        rd(3'd4, d); chk("R8 rx saturates at 0xFFFF", d, 16'hFFFF);
        rd(3'd0, d); chk("R9 rx half not refired", d, 16'h0001);
        rd(3'd4, d); chk("R8 rx cleared after saturation", d, 16'h0000);
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset();
        t_latch();
        t_enable();
        t_collide();
        t_polarity();
        t_force();
        t_fc_count();
        t_fc_half();
        t_rx_qual();
        t_rx_half();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule